// File: doc/BRIEF.md
# Rotation-Aware LCD Address Window Command Generator

This block produces the command bytes that a paged grayscale LCD controller needs when the displayed image is rotated in steps of 90 degrees. It handles two kinds of request. A configure request emits a RAM address-control byte and a display mapping byte. Both bytes depend on the chosen rotation. A window request emits four bytes that set the column and the page of a write window. The start coordinate is taken from (x, y). Each page of display RAM holds two lines, so the page address is the chosen coordinate divided by two.

Rotation is encoded as 0 = 0°, 1 = 90°, 2 = 180° and 3 = 270°. The rotation decides which coordinate goes to the column and which goes to the page. It also decides the increment order and the mirror bits. Bytes leave over a valid/ready stream, and a data/command flag marks every byte as a command. A single-cycle done pulse follows the last byte of each sequence. Requests are taken only while the generator is idle.

Top module: `lcd_win_cmdgen`

## Requirements
- R1: After reset, cmd_valid and seq_done are 0 and req_ready is 1.
- R2: A configure request emits exactly two bytes. The first is the RAM control byte 0x88 | (pf<<1) | 1, where pf = 1 for rotation codes 1 and 3 and pf = 0 for codes 0 and 2. Bit 2 of this byte is always 0.
- R3: The second configure byte is 0xC0 | (mirror_y<<2) | (mirror_x<<1), and its bit 0 is always 0. The mirror bits by rotation code are: code 0 gives X only; code 1 gives neither; code 2 gives Y only; code 3 gives both.
- R4: A window request emits four bytes in this order: c & 0x0F, then 0x10 | (c>>4), then 0x60 | ((p>>1) & 0x0F), then 0x70 | (p>>5). Here c is the column coordinate and p is the page coordinate.
- R5: For rotation codes 0 and 2, c = x and p = y. For codes 1 and 3, c = y and p = x.
- R6: While cmd_valid is 1 and cmd_ready is 0, cmd_valid stays 1 and cmd_data does not change.
- R7: seq_done is 1 for exactly one cycle. That cycle directly follows the clock edge that completes the last byte of a sequence.
- R8: While a sequence is in progress, req_ready is 0. Any request that arrives then is ignored: the bytes already in progress are unchanged and no extra sequence follows.
- R9: If cfg_req and win_req are both high on an idle cycle, the configure sequence is emitted and the window request is dropped.
- R10: cmd_dc is 0 (command) on every byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rot | input | 2 | Rotation code, sampled when a request is accepted |
| cfg_req | input | 1 | Request the configure sequence |
| win_req | input | 1 | Request the window sequence |
| x | input | CW | Window start x |
| y | input | CW | Window start y |
| req_ready | output | 1 | Idle; a request is accepted on this cycle |
| cmd_valid | output | 1 | Output byte valid |
| cmd_ready | input | 1 | Downstream accepts the byte |
| cmd_data | output | 8 | Command byte |
| cmd_dc | output | 1 | Data/command flag, 0 = command |
| seq_done | output | 1 | One-cycle pulse after the last byte |

## Verification
The assertions assume that requests are sampled only on cycles where req_ready is high. They also assume that cmd_ready may toggle freely, so byte stability must hold under any ready pattern. The stimulus drives all inputs on the falling edge and releases each request the cycle after it is accepted. It applies backpressure from a pseudo-random sequence. It also pulses conflicting requests deliberately while a sequence is in progress, to show that they are dropped.

// File: rtl/lcd_win_cmdgen.sv
module lcd_win_cmdgen #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    rot,
  input  logic          cfg_req,
  input  logic          win_req,
  input  logic [CW-1:0] x,
  input  logic [CW-1:0] y,
  output logic          req_ready,
  output logic          cmd_valid,
  input  logic          cmd_ready,
  output logic [7:0]    cmd_data,
  output logic          cmd_dc,
  output logic          seq_done
);
  localparam int LASTW = 3;
  localparam int LASTC = 1;

  logic       busy, is_win, done_q;
  logic [1:0] rot_q, idx;
  logic [7:0] col_q, pg_q;
  logic [7:0] xe, ye;

  assign xe = 8'(x);
  assign ye = 8'(y);

  wire take = !busy && (cfg_req || win_req);
  wire hs   = busy && cmd_ready;
  wire last = is_win ? (idx == 2'(LASTW)) : (idx == 2'(LASTC));

  wire mir_x = (rot_q == 2'd0) || (rot_q == 2'd3);
  wire mir_y = rot_q[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      is_win <= 1'b0;
      rot_q  <= '0;
      col_q  <= '0;
      pg_q   <= '0;
      idx    <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= hs && last;
      if (take) begin
        busy   <= 1'b1;
        is_win <= !cfg_req;
        rot_q  <= rot;
        idx    <= '0;
        col_q  <= rot[0] ? ye : xe;
        pg_q   <= rot[0] ? xe : ye;
      end else if (hs) begin
        if (last) busy <= 1'b0;
        idx <= idx + 2'd1;
      end
    end
  end

  always_comb begin
    if (is_win) begin
      unique case (idx)
        2'd0: cmd_data = {4'h0, col_q[3:0]};
        2'd1: cmd_data = {4'h1, col_q[7:4]};
        2'd2: cmd_data = {4'h6, pg_q[4:1]};
        default: cmd_data = {5'b01110, pg_q[7:5]};
      endcase
    end else if (idx == 2'd0) begin
      cmd_data = {5'b10001, 1'b0, rot_q[0], 1'b1};
    end else begin
      cmd_data = {5'b11000, mir_y, mir_x, 1'b0};
    end
  end

  assign req_ready = !busy;
  assign cmd_valid = busy;
  assign cmd_dc    = 1'b0;
  assign seq_done  = done_q;
endmodule

// File: rtl/lcd_win_cmdgen_chk.sv
module lcd_win_cmdgen_chk #(
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    rot,
  input logic          cfg_req,
  input logic          win_req,
  input logic [CW-1:0] x,
  input logic [CW-1:0] y,
  input logic          req_ready,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [7:0]    cmd_data,
  input logic          cmd_dc,
  input logic          seq_done
);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_data));

  assert_busy_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !req_ready);

  assert_done_after_hs_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> $past(cmd_valid && cmd_ready));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |=> !seq_done);

  assert_ram_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_data[7:3] == 5'b10001 |-> !cmd_data[2] && cmd_data[0]);

  assert_map_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_data[7:3] == 5'b11000 |-> !cmd_data[0]);

  assert_cmd_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !cmd_dc);
endmodule

bind lcd_win_cmdgen lcd_win_cmdgen_chk #(.CW(CW)) u_chk (.*);

// File: tb/lcd_win_cmdgen_tb.sv
module lcd_win_cmdgen_tb;
  logic clk = 0, rst_n = 0;
  logic [1:0] rot = 0;
  logic cfg_req = 0, win_req = 0, cmd_ready = 0;
  logic [7:0] x = 0, y = 0;
  logic req_ready, cmd_valid, cmd_dc, seq_done;
  logic [7:0] cmd_data;
  int nchk = 0, nfail = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit intrude = 0;

  always #2.5 clk = ~clk;

  lcd_win_cmdgen #(.CW(8)) u_dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0] | lfsr[3];
  endfunction

  task automatic run(input bit both, input bit win, input logic [1:0] r,
                     input logic [7:0] xi, input logic [7:0] yi);
    logic [7:0] exp [4];
    int n;
    logic [7:0] c, p;
    bit cfg;
    cfg = both || !win;
    c = r[0] ? yi : xi;
    p = r[0] ? xi : yi;
    if (cfg) begin
      n = 2;
      exp[0] = 8'h88 | {6'b0, r[0], 1'b0} | 8'h01;
      exp[1] = 8'hC0 | {5'b0, r[1], (r == 2'd0 || r == 2'd3), 1'b0};
    end else begin
      n = 4;
      exp[0] = c & 8'h0F;
      exp[1] = 8'h10 | (c >> 4);
      exp[2] = 8'h60 | ((p >> 1) & 8'h0F);
      exp[3] = 8'h70 | (p >> 5);
    end
    @(negedge clk);
    rot = r; x = xi; y = yi;
    cfg_req = cfg; win_req = win || both;
    @(negedge clk);
    cfg_req = 0; win_req = 0;
    for (int k = 0; k < n; ) begin
      chk(cmd_valid === 1'b1, "R8 valid", int'(cmd_valid), 1);
      chk(cmd_data === exp[k], cfg ? (k == 0 ? "R2" : "R3 R9") : "R4 R5 R6",
          int'(cmd_data), int'(exp[k]));
      chk(cmd_dc === 1'b0 && req_ready === 1'b0, "R10 R8 flags",
          int'({cmd_dc, req_ready}), 0);
      cmd_ready = rnd();
      if (intrude) begin
        win_req = 1; cfg_req = 1; rot = ~r; x = ~xi; y = ~yi;
      end
      @(posedge clk);
      if (cmd_ready) k++;
      @(negedge clk);
      win_req = 0; cfg_req = 0;
      if (k < n) chk(seq_done === 1'b0, "R7 early", int'(seq_done), 0);
    end
    cmd_ready = 0;
    chk(seq_done === 1'b1 && cmd_valid === 1'b0 && req_ready === 1'b1,
        "R7 done", int'({seq_done, cmd_valid, req_ready}), 3'b101);
    @(negedge clk);
    chk(seq_done === 1'b0 && cmd_valid === 1'b0, "R7 R8 after",
        int'({seq_done, cmd_valid}), 0);
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_valid === 0 && seq_done === 0 && req_ready === 1, "R1 reset",
        int'({cmd_valid, seq_done, req_ready}), 1);
    rst_n = 1;
    @(negedge clk);
    chk(cmd_valid === 0 && req_ready === 1, "R1 idle", int'({cmd_valid, req_ready}), 1);
    for (int r = 0; r < 4; r++) run(0, 0, 2'(r), 8'h00, 8'h00);
    for (int r = 0; r < 4; r++)
      for (int v = 0; v < 256; v++)
        run(0, 1, 2'(r), 8'(v), 8'((v * 37 + 11) & 255));
    for (int r = 0; r < 4; r++) run(1, 1, 2'(r), 8'h5A, 8'hC3);
    intrude = 1;
    for (int r = 0; r < 4; r++) begin
      run(0, 1, 2'(r), 8'h9E, 8'h27);
      run(0, 0, 2'(r), 8'h00, 8'h00);
    end
    intrude = 0;
    repeat (4) begin
      @(negedge clk);
      chk(cmd_valid === 0, "R8 nothing queued", int'(cmd_valid), 0);
    end
    $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule